// File: doc/BRIEF.md
# Three-Phase Regular-Sampled PWM Engine

This block turns a stored power waveform into three pulse-width-modulated phase signals for an inverter bridge. A symmetric triangle carrier, derived from the clock through a power-of-two prescaler, is compared against a modulation level for each phase. The level comes from a 4-bit waveform sample fetched from an external lookup memory. Samples are refreshed at both the top and the bottom turning points of the carrier. Each sample then holds for the following half carrier period.

A phase accumulator steps through the waveform table once per sample instant. The step is a 12-bit frequency word shifted left by a range code. The red phase reads the table at the accumulator position. The two other phases read at fixed offsets of one third and two thirds of the table, and a direction input chooses which of them gets which offset. An amplitude factor scales each sample about mid-scale, and overmodulation saturates. A frequency word of zero freezes the accumulator and forces every phase to exactly half duty. A zero-phase pulse marks each wrap of the accumulator.

Top module: `pwm3_engine`

## Requirements
- R1: The carrier period is 512·n clocks. n is 1, 2, 4, 8, 16 or 32 for `carr_sel_i` codes 000 to 101, and codes 110 and 111 also give n = 32. The triangle is updated only once every n clocks.
- R2: The modulation level L is computed in the range 0..256. Over any window of one carrier period, a phase output is high for exactly 2·L·n clocks, because the output is high while L exceeds the 8-bit triangle value.
- R3: With sample s (0..15) and amplitude a (0..255, where 128 is unity), L = 128 + floor((2s−15)·a/16), clamped to 0..256. A level of 256 keeps the phase high for the whole period, and a level of 0 keeps it low.
- R4: The memory is read at both carrier turning points, so the red-phase address is fetched twice per carrier period. A new memory value takes effect within one half period plus a few clocks.
- R5: `pwm_o` bit 0 is red, bit 1 is yellow and bit 2 is blue. With `rev_i` = 0, yellow reads the red address + 683 and blue reads the red address + 1365, both modulo 2048.
- R6: With `rev_i` = 1, the yellow and blue offsets are swapped: yellow reads +1365 and blue reads +683.
- R7: At every sample instant the 22-bit accumulator advances by `freq_i` << `rng_i`, and the top 11 bits give the red address. On each accumulator wrap, `zpp_o` rises at that sample instant and stays high for one half carrier period.
- R8: When `freq_i` is zero, the accumulator holds its value, `zpp_o` stays low, and every phase runs at 50% duty whatever the memory holds.
- R9: While `rst_n` is low, `pwm_o` and `zpp_o` are low, and the accumulator and carrier return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| carr_sel_i | input | 3 | Carrier prescale code |
| freq_i | input | 12 | Waveform step word; zero gives half duty |
| rng_i | input | 3 | Left shift applied to the step word |
| rev_i | input | 1 | Swaps the yellow and blue table offsets |
| amp_i | input | 8 | Amplitude factor, 128 is unity |
| mem_data_i | input | 4 | Sample returned by the lookup memory in the same cycle |
| mem_addr_o | output | 11 | Lookup memory address, registered |
| pwm_o | output | 3 | Phase outputs: red, yellow, blue |
| zpp_o | output | 1 | Zero-phase pulse |

## Verification
Some properties are checked on every cycle. The triangle only moves on prescaler ticks and moves one step at a time. The sequencer is idle whenever a turning point arrives. The accumulator stays put under a zero frequency word. The zero-phase pulse changes only at sample instants. A saturated level forces its phase fully on or fully off. Other behaviour shows only in the bench's scenarios: the exact period length for each prescale code, the high-time count across the sweep of samples and amplitudes, the phase offsets in both directions, the two fetches per period and the wrap interval of the zero-phase pulse.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
   localparam int NPH      = 3;
   localparam int PH_IDX_W = $clog2(NPH);

   typedef enum logic [PH_IDX_W-1:0] {
      PH_RED = 2'd0,
      PH_YEL = 2'd1,
      PH_BLU = 2'd2
   } phase_e;

   // Which table offset a phase uses; reverse order swaps the non-red phases.
   function automatic logic [PH_IDX_W-1:0] order_index(input logic [PH_IDX_W-1:0] k,
                                                       input logic rev);
      return (rev && k != '0) ? PH_IDX_W'(NPH) - k : k;
   endfunction
endpackage

// File: rtl/pwm3_carrier.sv
module pwm3_carrier #(
   parameter int CARR_W  = 8,
   parameter int SEL_W   = 3,
   parameter int MAX_SEL = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  sel_i,
   output logic [CARR_W-1:0] tri_o,
   output logic              peak_o
);
   localparam int PRE_W = (MAX_SEL > 0) ? MAX_SEL : 1;
   localparam logic [CARR_W-1:0] TOP = '1;

   logic [SEL_W-1:0]  sel_c;
   logic [PRE_W-1:0]  pre_q, lim;
   logic [CARR_W-1:0] tri_q;
   logic              up_q, tick, peak;

   always_comb begin
      sel_c = (int'(sel_i) > MAX_SEL) ? SEL_W'(MAX_SEL) : sel_i;
      lim   = PRE_W'((1 << sel_c) - 1);
      tick  = (pre_q == lim);
      peak  = tick && (up_q ? (tri_q == TOP) : (tri_q == '0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         tri_q <= '0;
         up_q  <= 1'b1;
      end else begin
         pre_q <= tick ? '0 : pre_q + 1'b1;
         if (tick) begin
            if (peak)      up_q  <= ~up_q;
            else if (up_q) tri_q <= tri_q + 1'b1;
            else           tri_q <= tri_q - 1'b1;
         end
      end
   end

   assign tri_o  = tri_q;
   assign peak_o = peak;

   AST_TRI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(tri_q)); // R1
   AST_TRI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !peak) |=> (tri_q == $past(tri_q) + 1'b1 || tri_q == $past(tri_q) - 1'b1)); // R1
endmodule

// File: rtl/pwm3_phase_acc.sv
module pwm3_phase_acc
   import pwm3_pkg::*;
#(
   parameter int ACC_W  = 22,
   parameter int FREQ_W = 12,
   parameter int RNG_W  = 3,
   parameter int ADDR_W = 11,
   parameter int DATA_W = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         peak_i,
   input  logic [FREQ_W-1:0]            freq_i,
   input  logic [RNG_W-1:0]             rng_i,
   input  logic                         rev_i,
   input  logic [DATA_W-1:0]            mem_data_i,
   output logic [ADDR_W-1:0]            mem_addr_o,
   output logic                         zpp_o,
   output logic [NPH-1:0][DATA_W-1:0]   samp_o
);
   localparam int SEQ_W = $clog2(NPH + 2);

   logic [ACC_W-1:0]                 acc_q, inc;
   logic [ACC_W:0]                   sum;
   logic                             zpp_q, commit_q;
   logic [SEQ_W-1:0]                 seq_q;
   logic [NPH-1:0][DATA_W-1:0]       pend_q, samp_q;
   logic [NPH-1:0][ADDR_W-1:0]       off_w;
   logic [ADDR_W-1:0]                base, addr_c;

   for (genvar k = 0; k < NPH; k++) begin : g_off
      assign off_w[k] = ADDR_W'((k * (2 ** ADDR_W) + NPH / 2) / NPH);
   end

   always_comb begin
      inc    = ACC_W'(freq_i) << rng_i;
      sum    = {1'b0, acc_q} + {1'b0, inc};
      base   = acc_q[ACC_W-1 -: ADDR_W];
      addr_c = base;
      for (int k = 0; k < NPH; k++) begin
         if (int'(seq_q) == k + 1)
            addr_c = base + off_w[order_index(PH_IDX_W'(k), rev_i)];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q      <= '0;
         zpp_q      <= 1'b0;
         seq_q      <= '0;
         commit_q   <= 1'b0;
         pend_q     <= '0;
         samp_q     <= '0;
         mem_addr_o <= '0;
      end else begin
         commit_q <= 1'b0;
         if (peak_i) begin
            acc_q <= sum[ACC_W-1:0];
            zpp_q <= sum[ACC_W];
            seq_q <= SEQ_W'(1);
         end else if (seq_q != '0) begin
            seq_q <= (int'(seq_q) == NPH + 1) ? '0 : seq_q + 1'b1;
         end
         if (seq_q != '0 && int'(seq_q) <= NPH) mem_addr_o <= addr_c;
         for (int k = 0; k < NPH; k++) begin
            if (int'(seq_q) == k + 2) pend_q[k] <= mem_data_i;
         end
         if (int'(seq_q) == NPH + 1) commit_q <= 1'b1;
         if (commit_q) samp_q <= pend_q;
      end
   end

   assign zpp_o  = zpp_q;
   assign samp_o = samp_q;

   AST_FREQ_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_i == '0) |=> $stable(acc_q)); // R8
   AST_ZPP_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      !peak_i |=> $stable(zpp_o)); // R7
   AST_SEQ_IDLE_AT_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
      peak_i |-> (seq_q == '0)); // R4
endmodule

// File: rtl/pwm3_modulator.sv
module pwm3_modulator
   import pwm3_pkg::*;
#(
   parameter int DATA_W = 4,
   parameter int AMP_W  = 8,
   parameter int CARR_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NPH-1:0][DATA_W-1:0]  samp_i,
   input  logic [AMP_W-1:0]            amp_i,
   input  logic                        hold_mid_i,
   input  logic [CARR_W-1:0]           tri_i,
   output logic [NPH-1:0]              pwm_o
);
   localparam int LVL_W = CARR_W + 1;
   localparam int PW    = DATA_W + AMP_W + 3;
   localparam int SH    = DATA_W + AMP_W - CARR_W;
   localparam int SMAX  = 2 ** DATA_W - 1;
   localparam int FULL  = 2 ** CARR_W;
   localparam int MID   = FULL / 2;

   for (genvar k = 0; k < NPH; k++) begin : g_ph
      logic signed [PW-1:0] ctr, prod, lsum;
      logic [LVL_W-1:0]     lvl;
      logic                 pq;

      always_comb begin
         ctr  = $signed(PW'({samp_i[k], 1'b0})) - $signed(PW'(SMAX));
         prod = ctr * $signed(PW'(amp_i));
         lsum = (prod >>> SH) + $signed(PW'(MID));
         if (hold_mid_i)                      lvl = LVL_W'(MID);
         else if (lsum < 0)                   lvl = '0;
         else if (lsum > $signed(PW'(FULL)))  lvl = LVL_W'(FULL);
         else                                 lvl = LVL_W'(lsum);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pq <= 1'b0;
         else        pq <= (lvl > {1'b0, tri_i});
      end

      assign pwm_o[k] = pq;

      AST_FULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
         (lvl == LVL_W'(FULL)) |=> pwm_o[k]); // R3
      AST_FULL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
         (lvl == '0) |=> !pwm_o[k]); // R3
   end
endmodule

// File: rtl/pwm3_engine.sv
module pwm3_engine
   import pwm3_pkg::*;
#(
   parameter int CARR_W  = 8,
   parameter int SEL_W   = 3,
   parameter int MAX_SEL = 5,
   parameter int FREQ_W  = 12,
   parameter int RNG_W   = 3,
   parameter int ACC_W   = 22,
   parameter int ADDR_W  = 11,
   parameter int DATA_W  = 4,
   parameter int AMP_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  carr_sel_i,
   input  logic [FREQ_W-1:0] freq_i,
   input  logic [RNG_W-1:0]  rng_i,
   input  logic              rev_i,
   input  logic [AMP_W-1:0]  amp_i,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [NPH-1:0]    pwm_o,
   output logic              zpp_o
);
   if (MAX_SEL >= 2 ** SEL_W) begin : g_bad_sel
      $error("carrier select field too narrow for MAX_SEL");
   end
   if (FREQ_W + 2 ** RNG_W - 1 > ACC_W) begin : g_bad_acc
      $error("accumulator too narrow for shifted step word");
   end
   if (ADDR_W > ACC_W) begin : g_bad_addr
      $error("address wider than accumulator");
   end
   if (DATA_W + AMP_W < CARR_W) begin : g_bad_scale
      $error("sample and amplitude too narrow for carrier resolution");
   end

   logic [CARR_W-1:0]          tri_w;
   logic                       peak_w;
   logic [NPH-1:0][DATA_W-1:0] samp_w;
   logic                       hold_mid;

   assign hold_mid = (freq_i == '0);

   pwm3_carrier #(.CARR_W(CARR_W), .SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_carrier (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_i  (carr_sel_i),
      .tri_o  (tri_w),
      .peak_o (peak_w)
   );

   pwm3_phase_acc #(.ACC_W(ACC_W), .FREQ_W(FREQ_W), .RNG_W(RNG_W),
                    .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .peak_i     (peak_w),
      .freq_i     (freq_i),
      .rng_i      (rng_i),
      .rev_i      (rev_i),
      .mem_data_i (mem_data_i),
      .mem_addr_o (mem_addr_o),
      .zpp_o      (zpp_o),
      .samp_o     (samp_w)
   );

   pwm3_modulator #(.DATA_W(DATA_W), .AMP_W(AMP_W), .CARR_W(CARR_W)) u_mod (
      .clk        (clk),
      .rst_n      (rst_n),
      .samp_i     (samp_w),
      .amp_i      (amp_i),
      .hold_mid_i (hold_mid),
      .tri_i      (tri_w),
      .pwm_o      (pwm_o)
   );

   AST_RST_OUT_LOW: assert property (@(posedge clk)
      !rst_n |=> (pwm_o == '0 && !zpp_o)); // R9
endmodule

// File: tb/pwm3_engine_tb.sv
module pwm3_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  carr_sel = 3'd0;
   logic [11:0] freq = 12'd1;
   logic [2:0]  rng = 3'd0;
   logic        rev = 1'b0;
   logic [7:0]  amp = 8'd128;
   logic [3:0]  mem_data;
   logic [10:0] mem_addr;
   logic [2:0]  pwm;
   logic        zpp;
   logic [3:0]  mem [0:2047];

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   assign mem_data = mem[mem_addr];

   pwm3_engine u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .carr_sel_i (carr_sel),
      .freq_i     (freq),
      .rng_i      (rng),
      .rev_i      (rev),
      .amp_i      (amp),
      .mem_data_i (mem_data),
      .mem_addr_o (mem_addr),
      .pwm_o      (pwm),
      .zpp_o      (zpp)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_lvl(input int s, input int a);
      int p, d;
      p = (2 * s - 15) * a;
      d = (p >= 0) ? p / 16 : -((-p + 15) / 16);
      d = d + 128;
      if (d < 0)   d = 0;
      if (d > 256) d = 256;
      return d;
   endfunction

   task automatic fill(input int v);
      for (int i = 0; i < 2048; i++) mem[i] = 4'(v);
   endtask

   task automatic measure(input int win, output int h0, output int h1, output int h2, output int hz);
      h0 = 0; h1 = 0; h2 = 0; hz = 0;
      for (int i = 0; i < win; i++) begin
         @(negedge clk);
         h0 += int'(pwm[0]);
         h1 += int'(pwm[1]);
         h2 += int'(pwm[2]);
         hz += int'(zpp);
      end
   endtask

   function automatic logic pick(input bit use_zpp);
      return use_zpp ? zpp : pwm[0];
   endfunction

   task automatic wait_rise(input bit use_zpp);
      logic p, c;
      @(negedge clk);
      p = pick(use_zpp);
      forever begin
         @(negedge clk);
         c = pick(use_zpp);
         if (c && !p) break;
         p = c;
      end
   endtask

   task automatic span(input bit use_zpp, output int len, output int hi);
      logic p, c;
      len = 0; hi = 1; p = 1'b1;
      forever begin
         @(negedge clk);
         c = pick(use_zpp);
         len++;
         if (c && !p) break;
         if (c) hi++;
         p = c;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9", "pwm during reset", int'(pwm), 0);
      chk("R9", "zpp during reset", int'(zpp), 0);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (199000) @(posedge clk);
      if (!done) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      int h0, h1, h2, hz, len, hi, rd;
      int sels[3];
      int amps[3];
      logic [10:0] pa;
      sels = '{0, 2, 7};
      amps = '{0, 128, 255};
      fill(8);
      do_reset();

      // R1: carrier period and high time per prescale code (s=8, a=128 -> L=136)
      foreach (sels[i]) begin
         int n;
         n = (sels[i] > 5) ? 32 : (1 << sels[i]);
         @(negedge clk);
         carr_sel = 3'(sels[i]);
         wait_rise(1'b0);
         wait_rise(1'b0);
         span(1'b0, len, hi);
         chk("R1", $sformatf("period sel=%0d", sels[i]), len, 512 * n);
         chk("R1", $sformatf("high time sel=%0d", sels[i]), hi, 2 * 136 * n);
      end
      carr_sel = 3'd0;

      // R2 / R3 / R4: sweep of samples and amplitudes, all phases
      for (int s = 0; s < 16; s++) begin
         foreach (amps[j]) begin
            string rq;
            int e;
            fill(s);
            amp = 8'(amps[j]);
            repeat (300) @(negedge clk);
            measure(512, h0, h1, h2, hz);
            e = 2 * exp_lvl(s, amps[j]);
            rq = (amps[j] == 255) ? "R3" : "R2";
            chk(rq, $sformatf("red s=%0d a=%0d", s, amps[j]), h0, e);
            chk(rq, $sformatf("yellow s=%0d a=%0d", s, amps[j]), h1, e);
            chk(rq, $sformatf("blue s=%0d a=%0d", s, amps[j]), h2, e);
         end
      end

      // R5 / R6 / R4: phase offsets, both directions, with accumulator at zero
      fill(5);
      mem[0] = 4'd2; mem[683] = 4'd9; mem[1365] = 4'd14;
      amp = 8'd128; freq = 12'd1; rng = 3'd0; rev = 1'b0;
      do_reset();
      repeat (600) @(negedge clk);
      measure(512, h0, h1, h2, hz);
      chk("R5", "red fwd", h0, 2 * exp_lvl(2, 128));
      chk("R5", "yellow fwd", h1, 2 * exp_lvl(9, 128));
      chk("R5", "blue fwd", h2, 2 * exp_lvl(14, 128));
      rd = 0;
      pa = mem_addr;
      for (int i = 0; i < 512; i++) begin
         @(negedge clk);
         if (mem_addr == 11'd0 && pa != 11'd0) rd++;
         pa = mem_addr;
      end
      chk("R4", "red fetches per period", rd, 2);
      rev = 1'b1;
      repeat (300) @(negedge clk);
      measure(512, h0, h1, h2, hz);
      chk("R6", "red rev", h0, 2 * exp_lvl(2, 128));
      chk("R6", "yellow rev", h1, 2 * exp_lvl(14, 128));
      chk("R6", "blue rev", h2, 2 * exp_lvl(9, 128));
      rev = 1'b0;

      // R8: zero word gives half duty and no wrap pulse
      for (int i = 0; i < 2048; i++) mem[i] = 4'(i % 16);
      amp = 8'd255; freq = 12'd0;
      repeat (300) @(negedge clk);
      measure(512, h0, h1, h2, hz);
      chk("R8", "red half duty", h0, 256);
      chk("R8", "yellow half duty", h1, 256);
      chk("R8", "blue half duty", h2, 256);
      chk("R8", "zpp quiet", hz, 0);

      // R7: wrap pulse spacing; step 2^17 wraps every 32 samples
      fill(8); amp = 8'd128;
      freq = 12'd2048; rng = 3'd6;
      wait_rise(1'b1);
      span(1'b1, len, hi);
      chk("R7", "zpp period 2048<<6", len, 8192);
      chk("R7", "zpp width 2048<<6", hi, 256);
      freq = 12'd1024; rng = 3'd7;
      wait_rise(1'b1);
      span(1'b1, len, hi);
      chk("R7", "zpp period 1024<<7", len, 8192);
      chk("R7", "zpp width 1024<<7", hi, 256);

      do_reset();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule